// File: doc/BRIEF.md
# I2C Slave Port to a 32-bit Register Bank

This block lets an external I2C master read and write a bank of 32-bit registers. It samples the open-drain SCL and SDA lines with the system clock and finds start, repeated-start and stop conditions. It answers one fixed 7-bit device address. It keeps an 8-bit register pointer, and a parallel register-bus strobe carries every 32-bit word to or from the bank. Each word travels on the wire as four bytes, most significant byte first.

A write transaction first loads the pointer from an index byte. Each group of four data bytes that follows writes one register, and the pointer steps after every write. If the master ends the transaction after the index byte, the pointer is set and nothing is written. A read transaction streams registers from the pointer onward. The master's acknowledge on each fourth byte decides whether another register follows. Whether the pointer moves depends on single versus burst reads. The register bank sees the byte address, which is the pointer times four. The pad is open-drain: `sda_oe` high pulls SDA low.

Top module: `i2c_dword_slave`

## Requirements
- R1: A control byte is received bit 7 first. Bits 7:1 hold the device address 7'b0001010 and bit 0 is the direction (0 = write, 1 = read). When the address matches, the block pulls SDA low in the acknowledge slot.
- R2: When the control byte carries another address, the block does not acknowledge. Until the next start condition it never drives SDA, never strobes the register bus and leaves the pointer unchanged.
- R3: In a write transaction, the block acknowledges the byte after the control byte and loads it into the pointer. `reg_addr` then shows that index times four, with bits 1:0 at zero.
- R4: A stop or repeated start right after the index byte writes nothing, and the pointer keeps the new index for later reads.
- R5: In a read transaction, the block drives data from the falling SCL edge that ends the control-byte acknowledge. It sends four bytes per register, bit 31 first. Each read strobe fetches the register at the current `reg_addr`.
- R6: When the master gives no acknowledge on the first register's fourth byte (single read), the pointer is unchanged afterwards.
- R7: When the master acknowledges a fourth byte, the pointer steps by one and the next register follows. In such a burst, the fourth byte that ends with no acknowledge also steps the pointer.
- R8: The pointer wraps from 255 to 0.
- R9: Data bytes after the index are collected MSB first and acknowledged. After the fourth one, a single write strobe presents the word at the current address, and the pointer then steps by one.
- R10: A start or stop condition discards a word with fewer than four bytes received, and no write strobe occurs.
- R11: The block changes SDA only while SCL is low. A falling SDA with SCL high is a start, and a rising SDA with SCL high is a stop.
- R12: After reset the pointer is 0, SDA is released and no strobe is active. Each `reg_we` or `reg_re` strobe lasts exactly one clock.
- R13: With a 250 MHz system clock, transfers at 100 kHz and 400 kHz SCL behave as in R3 to R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | High pulls SDA low |
| reg_addr | output | 10 | Byte address of the current register (pointer times four) |
| reg_wdata | output | 32 | Word to write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe; `reg_rdata` is taken in that cycle |
| reg_rdata | input | 32 | Word read from the register at `reg_addr` |

## Verification
The bench runs single-word writes and two-word burst writes. It also runs reads that follow a repeated start, reads that start from a pointer loaded earlier and closed by a stop, burst reads that cross the top of the pointer range, a foreign device address with traffic after it, and a write cut off after two data bytes. Single reads and bursts tell apart the two pointer rules. The wrap case separates a modulo pointer from a saturating one. The cut-off write and the index-only write show whether a strobe fires without a full word. One transfer at 100 kHz and one at 400 kHz show that timing at either rate does not change behaviour.

// File: rtl/i2c_dw_pkg.sv
package i2c_dw_pkg;

    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 32;
    localparam int WORD_BYT = WORD_W / BYTE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } link_state_e;

    typedef enum logic [1:0] {
        PH_CTRL,
        PH_INDEX,
        PH_DATA
    } rx_phase_e;

endpackage

// File: rtl/i2c_dw_sync.sv
module i2c_dw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t sync_d, sync_q;
    logic  scl_now;

    always_comb begin
        sync_d             = sync_q;
        sync_d.scl_pipe[0] = scl_i;
        sync_d.sda_pipe[0] = sda_i;
        for (int i = 1; i < STAGES; i++) begin
            sync_d.scl_pipe[i] = sync_q.scl_pipe[i-1];
            sync_d.sda_pipe[i] = sync_q.sda_pipe[i-1];
        end
        sync_d.scl_prev = sync_q.scl_pipe[STAGES-1];
        sync_d.sda_prev = sync_q.sda_pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign scl_now   = sync_q.scl_pipe[STAGES-1];
    assign sda_lvl   = sync_q.sda_pipe[STAGES-1];
    assign scl_rise  = scl_now & ~sync_q.scl_prev;
    assign scl_fall  = ~scl_now & sync_q.scl_prev;
    assign start_det = scl_now & sync_q.scl_prev & sync_q.sda_prev & ~sda_lvl;
    assign stop_det  = scl_now & sync_q.scl_prev & ~sync_q.sda_prev & sda_lvl;

endmodule

// File: rtl/i2c_dw_ctrl.sv
module i2c_dw_ctrl
    import i2c_dw_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b0001010,
    parameter int         DW       = WORD_W,
    parameter int         PTR_W    = BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_lvl,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [DW-1:0]    rd_data,
    output logic             sda_oe,
    output logic [PTR_W-1:0] ptr,
    output logic             wr_en,
    output logic [DW-1:0]    wr_data,
    output logic             rd_en,
    output logic             idle
);

    localparam int                 NBYTES  = DW / BYTE_W;
    localparam int                 BCNT_W  = $clog2(NBYTES);
    localparam int                 CNT_W   = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0]   BIT_END = CNT_W'(BYTE_W);
    localparam logic [BCNT_W-1:0]  BYT_END = BCNT_W'(NBYTES - 1);

    typedef struct packed {
        link_state_e       st;
        rx_phase_e         ph;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic              rw;
        logic [DW-1:0]     wacc;
        logic [BCNT_W-1:0] bcnt;
        logic              do_wr;
        logic [DW-1:0]     txbuf;
        logic              burst;
        logic              mack;
        logic [PTR_W-1:0]  ptr;
        logic              oe;
        logic              we;
        logic              re;
        logic [DW-1:0]     wdata;
    } ctl_t;

    ctl_t c_d, c_q;

    always_comb begin
        c_d    = c_q;
        c_d.we = 1'b0;
        c_d.re = 1'b0;
        if (c_q.we) begin
            c_d.ptr = c_q.ptr + 1'b1;
        end
        if (c_q.re) begin
            c_d.txbuf = rd_data;
        end

        if (start_det) begin
            c_d.st    = ST_RX;
            c_d.ph    = PH_CTRL;
            c_d.cnt   = '0;
            c_d.oe    = 1'b0;
            c_d.bcnt  = '0;
            c_d.do_wr = 1'b0;
        end else if (stop_det) begin
            c_d.st    = ST_IDLE;
            c_d.oe    = 1'b0;
            c_d.bcnt  = '0;
            c_d.do_wr = 1'b0;
        end else begin
            unique case (c_q.st)
                ST_RX: begin
                    if (scl_rise && c_q.cnt != BIT_END) begin
                        c_d.sh  = {c_q.sh[BYTE_W-2:0], sda_lvl};
                        c_d.cnt = c_q.cnt + 1'b1;
                    end else if (scl_fall && c_q.cnt == BIT_END) begin
                        unique case (c_q.ph)
                            PH_CTRL: begin
                                if (c_q.sh[BYTE_W-1:1] == DEV_ADDR) begin
                                    c_d.rw = c_q.sh[0];
                                    c_d.oe = 1'b1;
                                    c_d.st = ST_RX_ACK;
                                    if (c_q.sh[0]) begin
                                        c_d.re    = 1'b1;
                                        c_d.burst = 1'b0;
                                        c_d.bcnt  = '0;
                                    end
                                end else begin
                                    c_d.st = ST_IDLE;
                                end
                            end
                            PH_INDEX: begin
                                c_d.ptr = c_q.sh[PTR_W-1:0];
                                c_d.oe  = 1'b1;
                                c_d.st  = ST_RX_ACK;
                            end
                            default: begin
                                c_d.wacc = {c_q.wacc[DW-BYTE_W-1:0], c_q.sh};
                                c_d.oe   = 1'b1;
                                c_d.st   = ST_RX_ACK;
                                c_d.bcnt = c_q.bcnt + 1'b1;
                                if (c_q.bcnt == BYT_END) begin
                                    c_d.do_wr = 1'b1;
                                end
                            end
                        endcase
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        c_d.cnt = '0;
                        if (c_q.ph == PH_CTRL && c_q.rw) begin
                            c_d.st = ST_TX;
                            c_d.oe = ~c_q.txbuf[DW-1];
                        end else begin
                            c_d.st = ST_RX;
                            c_d.oe = 1'b0;
                            c_d.ph = (c_q.ph == PH_CTRL) ? PH_INDEX : PH_DATA;
                            if (c_q.do_wr) begin
                                c_d.we    = 1'b1;
                                c_d.wdata = c_q.wacc;
                                c_d.do_wr = 1'b0;
                            end
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        c_d.cnt = c_q.cnt + 1'b1;
                    end else if (scl_fall && c_q.cnt != '0) begin
                        c_d.txbuf = {c_q.txbuf[DW-2:0], 1'b0};
                        if (c_q.cnt == BIT_END) begin
                            c_d.oe = 1'b0;
                            c_d.st = ST_TX_ACK;
                        end else begin
                            c_d.oe = ~c_q.txbuf[DW-2];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        c_d.mack = ~sda_lvl;
                        if (c_q.bcnt == BYT_END) begin
                            if (!sda_lvl) begin
                                c_d.ptr   = c_q.ptr + 1'b1;
                                c_d.burst = 1'b1;
                                c_d.re    = 1'b1;
                            end else if (c_q.burst) begin
                                c_d.ptr = c_q.ptr + 1'b1;
                            end
                        end
                    end else if (scl_fall) begin
                        if (c_q.mack) begin
                            c_d.st   = ST_TX;
                            c_d.cnt  = '0;
                            c_d.oe   = ~c_q.txbuf[DW-1];
                            c_d.bcnt = c_q.bcnt + 1'b1;
                        end else begin
                            c_d.st = ST_IDLE;
                            c_d.oe = 1'b0;
                        end
                    end
                end
                default: begin
                    c_d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
            c_q.ph <= PH_CTRL;
        end else begin
            c_q <= c_d;
        end
    end

    assign sda_oe  = c_q.oe;
    assign ptr     = c_q.ptr;
    assign wr_en   = c_q.we;
    assign wr_data = c_q.wdata;
    assign rd_en   = c_q.re;
    assign idle    = (c_q.st == ST_IDLE);

endmodule

// File: rtl/i2c_dword_slave.sv
module i2c_dword_slave
    import i2c_dw_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b0001010,
    parameter int         SYNC_STAGES = 2,
    parameter int         PTR_W       = BYTE_W,
    parameter int         DATA_W      = WORD_W,
    parameter int         ADDR_W      = PTR_W + $clog2(DATA_W / BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [DATA_W-1:0] reg_rdata
);

    localparam int LOW_W = ADDR_W - PTR_W;

    logic             sda_lvl;
    logic             scl_rise;
    logic             scl_fall;
    logic             start_det;
    logic             stop_det;
    logic [PTR_W-1:0] ptr;
    logic             ctl_idle;

    i2c_dw_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_dw_ctrl #(
        .DEV_ADDR (DEV_ADDR),
        .DW       (DATA_W),
        .PTR_W    (PTR_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (reg_rdata),
        .sda_oe    (sda_oe),
        .ptr       (ptr),
        .wr_en     (reg_we),
        .wr_data   (reg_wdata),
        .rd_en     (reg_re),
        .idle      (ctl_idle)
    );

    assign reg_addr = {ptr, {LOW_W{1'b0}}};

endmodule

// File: rtl/i2c_dword_slave_chk.sv
module i2c_dword_slave_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe,
    input logic              reg_we,
    input logic              reg_re,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              idle
);

    AST_SDA_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i); // R11

    AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we); // R12

    AST_RE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> !reg_re); // R12

    AST_PTR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (reg_addr == $past(reg_addr) + ADDR_W'(4))); // R9

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !sda_oe); // R2

    AST_NO_STROBE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_re)); // R12

endmodule

bind i2c_dword_slave i2c_dword_slave_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .reg_we   (reg_we),
    .reg_re   (reg_re),
    .reg_addr (reg_addr),
    .idle     (ctl_idle)
);

// File: tb/test_i2c_dword_slave.sv
module test_i2c_dword_slave;

    localparam int FAST = 16;
    localparam int Q400 = 157;
    localparam int Q100 = 625;
    localparam int WD_CYCLES = 195000;
    localparam logic [7:0] CW = {7'b0001010, 1'b0};
    localparam logic [7:0] CR = {7'b0001010, 1'b1};

    logic        clk = 1'b0;
    logic        rst_n;
    logic        m_scl_low;
    logic        m_sda_low;
    logic        sda_oe;
    logic [9:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic        reg_we;
    logic        reg_re;
    logic [31:0] reg_rdata;
    logic        scl_line;
    logic        sda_line;

    always #2 clk = ~clk;

    assign scl_line = ~m_scl_low;
    assign sda_line = ~(m_sda_low | sda_oe);

    i2c_dword_slave i_i2c_dword_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_line),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .reg_rdata (reg_rdata)
    );

    function automatic logic [31:0] init_val(input int i);
        logic [7:0] b;
        b = i[7:0];
        return {b, ~b, 8'h5A, b ^ 8'hC3};
    endfunction

    // register bank on the parallel side
    logic [31:0] dev_mem [256];
    assign reg_rdata = dev_mem[reg_addr[9:2]];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) dev_mem[i] <= init_val(i);
        end else if (reg_we) begin
            dev_mem[reg_addr[9:2]] <= reg_wdata;
        end
    end

    logic [31:0] model [256];
    int          n_tests = 0;
    int          n_fail  = 0;
    int          qtr     = FAST;
    string       cur_req = "R9";
    logic        ack;
    logic [7:0]  got_byte;
    event        rx_evt;
    logic [7:0]  exp_rd[$];
    string       exp_rq[$];
    logic [9:0]  exp_wa[$];
    logic [31:0] exp_wd[$];
    int          wr_seen = 0;
    int          oe_viol = 0;
    int          long_pulse = 0;
    int          quiet_hits = 0;
    logic        watch_quiet = 1'b0;
    logic        oe_prev = 1'b0;
    logic        we_prev = 1'b0;
    logic        re_prev = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; tick(qtr);
        m_scl_low = 1'b0; tick(qtr);
        m_sda_low = 1'b1; tick(qtr);
        m_scl_low = 1'b1; tick(qtr);
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; tick(qtr);
        m_scl_low = 1'b0; tick(qtr);
        m_sda_low = 1'b0; tick(qtr);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic a);
        for (int i = 7; i >= 0; i--) begin
            m_sda_low = ~b[i]; tick(qtr);
            m_scl_low = 1'b0;  tick(2 * qtr);
            m_scl_low = 1'b1;  tick(qtr);
        end
        m_sda_low = 1'b0; tick(qtr);
        m_scl_low = 1'b0; tick(qtr);
        a = ~sda_line;    tick(qtr);
        m_scl_low = 1'b1; tick(qtr);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        m_sda_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            tick(qtr);
            m_scl_low = 1'b0; tick(qtr);
            b[i] = sda_line;  tick(qtr);
            m_scl_low = 1'b1; tick(qtr);
        end
        m_sda_low = give_ack; tick(qtr);
        m_scl_low = 1'b0;     tick(2 * qtr);
        m_scl_low = 1'b1;     tick(qtr);
        m_sda_low = 1'b0;
    endtask

    task automatic set_index(input logic [7:0] idx, input string req);
        bus_start();
        send_byte(CW, ack);
        chk(ack == 1'b1, "R1", "control byte (write) acknowledged", 64'(ack), 64'd1);
        send_byte(idx, ack);
        chk(ack == 1'b1, "R3", "index byte acknowledged", 64'(ack), 64'd1);
        cur_req = req;
    endtask

    task automatic send_word(input logic [7:0] idx, input logic [31:0] w, input string req);
        exp_wa.push_back({idx, 2'b00});
        exp_wd.push_back(w);
        model[idx] = w;
        for (int b = 0; b < 4; b++) begin
            send_byte(w[31 - 8 * b -: 8], ack);
            chk(ack == 1'b1, req, "data byte acknowledged", 64'(ack), 64'd1);
        end
    endtask

    task automatic rd_regs(input int n, input int first, input string req);
        logic [31:0] w;
        logic [7:0]  g;
        bus_start();
        send_byte(CR, ack);
        chk(ack == 1'b1, "R1", "control byte (read) acknowledged", 64'(ack), 64'd1);
        for (int r = 0; r < n; r++) begin
            w = model[(first + r) % 256];
            for (int b = 0; b < 4; b++) begin
                exp_rd.push_back(w[31 - 8 * b -: 8]);
                exp_rq.push_back(req);
                recv_byte(!(r == n - 1 && b == 3), g);
                got_byte = g;
                -> rx_evt;
            end
        end
        bus_stop();
        tick(8);
    endtask

    // scoreboard: read bytes
    initial begin
        forever begin
            @(rx_evt);
            if (exp_rd.size() == 0) begin
                chk(1'b0, "R5", "read byte with nothing expected", 64'(got_byte), 64'd0);
            end else begin
                logic [7:0] e;
                string      rq;
                e  = exp_rd.pop_front();
                rq = exp_rq.pop_front();
                chk(got_byte == e, rq, "read byte", 64'(got_byte), 64'(e));
            end
        end
    end

    // scoreboard: write strobes and line monitors
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_we) begin
                wr_seen++;
                if (exp_wa.size() == 0) begin
                    chk(1'b0, cur_req, "unexpected write strobe", 64'(reg_addr), 64'd0);
                end else begin
                    logic [9:0]  ea;
                    logic [31:0] ed;
                    ea = exp_wa.pop_front();
                    ed = exp_wd.pop_front();
                    chk(reg_addr == ea, "R9", "write address", 64'(reg_addr), 64'(ea));
                    chk(reg_wdata == ed, "R9", "write data", 64'(reg_wdata), 64'(ed));
                end
            end
            if (sda_oe != oe_prev && scl_line) oe_viol++;
            if ((reg_we && we_prev) || (reg_re && re_prev)) long_pulse++;
            if (watch_quiet && (sda_oe || reg_we || reg_re)) quiet_hits++;
        end
        oe_prev = sda_oe;
        we_prev = reg_we;
        re_prev = reg_re;
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        m_scl_low = 1'b0;
        m_sda_low = 1'b0;
        rst_n     = 1'b0;
        for (int i = 0; i < 256; i++) model[i] = init_val(i);
        tick(10);
        rst_n = 1'b1;
        tick(4);

        // R12 reset state
        chk(reg_addr == 10'd0, "R12", "pointer after reset", 64'(reg_addr), 64'd0);
        chk(sda_oe == 1'b0, "R12", "SDA released after reset", 64'(sda_oe), 64'd0);
        chk(!reg_we && !reg_re, "R12", "no strobe after reset", 64'({reg_we, reg_re}), 64'd0);

        // R9 single word write
        set_index(8'h05, "R9");
        send_word(8'h05, 32'h11223344, "R9");
        bus_stop(); tick(8);
        chk(reg_addr == 10'h018, "R9", "pointer after one write", 64'(reg_addr), 64'h018);
        chk(wr_seen == 1, "R12", "one strobe per word", 64'(wr_seen), 64'd1);

        // R5 R6 single read after a repeated start
        set_index(8'h05, "R4");
        rd_regs(1, 5, "R5");
        chk(reg_addr == 10'h014, "R6", "pointer after single read", 64'(reg_addr), 64'h014);

        // R7 burst read of two registers
        set_index(8'h10, "R4");
        rd_regs(2, 16, "R7");
        chk(reg_addr == 10'h048, "R7", "pointer after burst", 64'(reg_addr), 64'h048);

        // R2 foreign address
        watch_quiet = 1'b1;
        bus_start();
        send_byte({7'b0001011, 1'b0}, ack);
        chk(ack == 1'b0, "R2", "foreign address not acknowledged", 64'(ack), 64'd0);
        send_byte(8'h55, ack);
        send_byte(8'hAA, ack);
        chk(ack == 1'b0, "R2", "bytes after foreign address ignored", 64'(ack), 64'd0);
        bus_stop(); tick(8);
        watch_quiet = 1'b0;
        chk(quiet_hits == 0, "R2", "no drive or strobe while ignoring", 64'(quiet_hits), 64'd0);
        chk(reg_addr == 10'h048, "R2", "pointer kept", 64'(reg_addr), 64'h048);

        // R8 wrap across the top of the range
        set_index(8'hFF, "R4");
        rd_regs(2, 255, "R8");
        chk(reg_addr == 10'h004, "R8", "pointer wrapped", 64'(reg_addr), 64'h004);

        // R10 cut-off word
        set_index(8'h20, "R10");
        send_byte(8'hDE, ack);
        send_byte(8'hAD, ack);
        bus_stop(); tick(8);
        chk(reg_addr == 10'h080, "R10", "pointer after partial word", 64'(reg_addr), 64'h080);
        rd_regs(1, 32, "R10");
        chk(reg_addr == 10'h080, "R6", "pointer after single read", 64'(reg_addr), 64'h080);

        // R4 index-only write closed by stop
        set_index(8'h30, "R4");
        bus_stop(); tick(8);
        chk(reg_addr == 10'h0C0, "R4", "pointer loaded by index-only write", 64'(reg_addr), 64'h0C0);
        rd_regs(1, 48, "R4");

        // R9 burst write of two words
        set_index(8'h40, "R9");
        send_word(8'h40, 32'hCAFE0123, "R9");
        send_word(8'h41, 32'h0BADF00D, "R9");
        bus_stop(); tick(8);
        chk(reg_addr == 10'h108, "R9", "pointer after two writes", 64'(reg_addr), 64'h108);
        rd_regs(1, 66, "R9");
        cur_req = "R9";
        set_index(8'h40, "R9");
        rd_regs(2, 64, "R9");

        // R13 100 kHz index write, 400 kHz read
        qtr = Q100;
        set_index(8'h07, "R13");
        bus_stop(); tick(8);
        chk(reg_addr == 10'h01C, "R13", "pointer set at 100 kHz", 64'(reg_addr), 64'h01C);
        qtr = Q400;
        rd_regs(1, 7, "R13");
        chk(reg_addr == 10'h01C, "R13", "pointer after 400 kHz read", 64'(reg_addr), 64'h01C);
        qtr = FAST;

        tick(20);
        chk(exp_rd.size() == 0, "R5", "all expected read bytes seen", 64'(exp_rd.size()), 64'd0);
        chk(exp_wa.size() == 0, "R9", "all expected writes seen", 64'(exp_wa.size()), 64'd0);
        chk(oe_viol == 0, "R11", "SDA changed only with SCL low", 64'(oe_viol), 64'd0);
        chk(long_pulse == 0, "R12", "strobes last one cycle", 64'(long_pulse), 64'd0);
        summary();
        $finish;
    end

endmodule